// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block runs the power-up and power-down of a smart card contact set in a fixed order. A host starts a session by pulling an active-low command low while a card sits in the reader. The block then brings up the booster, the card supply, the data lines, the card clock and the card reset, in that order. When the command returns high it takes the contacts down in reverse order. All timing is counted in a unit T of a parameterised number of oscillator periods, 64 by default. The block steps in half units so that the 1.5T and T/2 points land on exact edges.

Any of three events during a session starts an emergency shutdown over the same reverse timeline: the card is pulled out, the card supply draws too much current, or the die runs hot. The event is latched and drives the active-low status output low until the host returns the command high. A supply alarm also forces a shutdown but leaves the status untouched. Outside a fault the status output reports whether a card is present. After the supply alarm clears, the block refuses to start for a parameterised hold time. All inputs are taken as synchronous to the oscillator clock.

Top module: `csq_sequencer`

## Requirements
- R1: After reset, and while the supply alarm is high or fewer than HOLD_CYCLES clocks have passed since it fell, no activation starts and all enables stay low.
- R2: An activation starts only when the command is low, a card is present, the alarm is low and the hold time has elapsed. boost_en rises on the first clock edge that samples these conditions (t1).
- R3: Counted from t1 in oscillator cycles with H = OSC_PER_T/2: vcc_en rises at 3H, io_en rises at 8H, and boost_en stays high throughout.
- R4: If rst_req is low at t1, clk_en rises at 8H. Otherwise clk_en rises on the first edge at or after 8H that samples rst_req low. If that has not happened by 14H, clk_en rises at 14H. Once started, the clock stays on until deactivation.
- R5: From t1+14H the session is active and card_rst equals rst_req combinationally. card_rst is low in every other state.
- R6: When a deactivation starts at edge t11, card_rst falls at t11. clk_en falls at t11+H, io_en at t11+2H, vcc_en at t11+3H and boost_en at t11+10H. An enable that was still off is never turned on during deactivation.
- R7: A card is present when pres_n is 0 or pres is 1. With no latched fault, stat_n equals presence.
- R8: During activation or an active session with the command low, card absence, ovc=1 or ovt=1 starts a deactivation at the next edge. It also latches a fault that holds stat_n low, even if the card reappears, until the edge after the command is seen high.
- R9: A supply alarm during activation or an active session starts a deactivation at the next edge without latching a fault.
- R10: At all times io_en implies vcc_en, vcc_en implies boost_en, clk_en implies io_en, and card_rst implies clk_en.
- R11: After a deactivation ends with the command still low, no new activation starts until the command has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_n | input | 1 | Session command, low requests a session |
| rst_req | input | 1 | Host card-reset request, high asserts reset |
| pres_n | input | 1 | Card presence, active low |
| pres | input | 1 | Card presence, active high |
| ovc | input | 1 | Card supply overcurrent flag |
| ovt | input | 1 | Overtemperature flag |
| alarm | input | 1 | Host supply alarm, high while supply is bad |
| boost_en | output | 1 | Supply booster enable |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Data line transceiver enable |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Reset driven to the card |
| stat_n | output | 1 | Active-low presence/fault status |

## Verification
The bench builds the block with OSC_PER_T = 8 and HOLD_CYCLES = 40. A half unit is then four clocks, a full activation 56 clocks and a deactivation 40 clocks. Every step of both timelines can therefore be compared cycle by cycle, including emergency shutdowns started part-way through activation. The short hold brings the post-alarm blocking window and its release within a few dozen cycles. Random release points of the reset request cover clock starts before, inside and after the window.

// File: rtl/csq_pkg.sv
package csq_pkg;

  typedef enum logic [2:0] {
    S_LOCK  = 3'd0,
    S_IDLE  = 3'd1,
    S_ACT   = 3'd2,
    S_ON    = 3'd3,
    S_DEACT = 3'd4
  } csq_state_e;

  localparam int unsigned STEP_W = 4;

  // timeline points in half units of T
  localparam logic [STEP_W-1:0] A_VCC = 4'd3;
  localparam logic [STEP_W-1:0] A_IO  = 4'd8;
  localparam logic [STEP_W-1:0] A_RUN = 4'd14;
  localparam logic [STEP_W-1:0] D_CLK = 4'd1;
  localparam logic [STEP_W-1:0] D_IO  = 4'd2;
  localparam logic [STEP_W-1:0] D_VCC = 4'd3;
  localparam logic [STEP_W-1:0] D_END = 4'd10;

  typedef struct packed {
    logic boost;
    logic vcc;
    logic io;
    logic clk;
  } csq_en_t;

endpackage

// File: rtl/csq_tick.sv
module csq_tick #(
  parameter int unsigned HALF_T = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (HALF_T > 1) ? $clog2(HALF_T) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(HALF_T - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !run)  cnt_d = '0;
    else if (tick)    cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/csq_hold.sv
module csq_hold #(
  parameter int unsigned HOLD_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm,
  output logic ready
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign ready  = (cnt_q == HW'(HOLD_CYCLES));
  assign cnt_en = alarm || !ready;

  always_comb begin
    cnt_d = cnt_q;
    if (alarm)       cnt_d = '0;
    else if (!ready) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/csq_sequencer.sv
module csq_sequencer
  import csq_pkg::*;
#(
  parameter int unsigned OSC_PER_T   = 64,
  parameter int unsigned HOLD_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_n,
  input  logic rst_req,
  input  logic pres_n,
  input  logic pres,
  input  logic ovc,
  input  logic ovt,
  input  logic alarm,
  output logic boost_en,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic stat_n
);
  localparam int unsigned HALF_T = OSC_PER_T / 2;

  csq_state_e          state_q, state_d;
  logic [STEP_W-1:0]   step_q, step_d;
  csq_en_t             en_q, en_d;
  logic                gate_q, gate_d;
  logic                flt_q, flt_d;
  logic                tick, ready, present, fault, in_seq, moved, stop;

  assign present = !pres_n || pres;
  assign fault   = !present || ovc || ovt;
  assign stop    = cmd_n || fault || alarm;
  assign in_seq  = (state_q == S_ACT) || (state_q == S_DEACT);
  assign moved   = (state_d != state_q);

  csq_tick #(.HALF_T(HALF_T)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_seq),
    .clr   (moved),
    .tick  (tick)
  );

  csq_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .alarm (alarm),
    .ready (ready)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_LOCK:  if (cmd_n) state_d = S_IDLE;
      S_IDLE:  if (!cmd_n && present && ready && !alarm) state_d = S_ACT;
      S_ACT: begin
        if (stop)                                  state_d = S_DEACT;
        else if (tick && step_q == A_RUN - 4'd1)   state_d = S_ON;
      end
      S_ON:    if (stop) state_d = S_DEACT;
      S_DEACT: if (tick && step_q == D_END - 4'd1) state_d = cmd_n ? S_IDLE : S_LOCK;
      default: state_d = S_LOCK;
    endcase
  end

  always_comb begin
    if (moved)     step_d = '0;
    else if (tick) step_d = step_q + 1'b1;
    else           step_d = step_q;
  end

  // clock gating choice is sampled as the activation starts
  assign gate_d = (state_q == S_IDLE && state_d == S_ACT) ? rst_req : gate_q;

  // enables: set-only while activating, clear-only while deactivating
  always_comb begin
    en_d = '0;
    unique case (state_d)
      S_ACT: begin
        en_d.boost = 1'b1;
        en_d.vcc   = en_q.vcc || (step_d >= A_VCC);
        en_d.io    = en_q.io  || (step_d >= A_IO);
        en_d.clk   = en_q.clk || ((step_d >= A_IO) && !(gate_d && rst_req));
      end
      S_ON:    en_d = '1;
      S_DEACT: begin
        en_d.boost = en_q.boost;
        en_d.vcc   = en_q.vcc && (step_d < D_VCC);
        en_d.io    = en_q.io  && (step_d < D_IO);
        en_d.clk   = en_q.clk && (step_d < D_CLK);
      end
      default: en_d = '0;
    endcase
  end

  always_comb begin
    flt_d = flt_q;
    if (cmd_n) flt_d = 1'b0;
    else if ((state_q == S_ACT || state_q == S_ON) && fault) flt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_LOCK;
      step_q  <= '0;
      en_q    <= '0;
      gate_q  <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      en_q    <= en_d;
      gate_q  <= gate_d;
      flt_q   <= flt_d;
    end
  end

  assign boost_en = en_q.boost;
  assign vcc_en   = en_q.vcc;
  assign io_en    = en_q.io;
  assign clk_en   = en_q.clk;
  assign card_rst = (state_q == S_ON) && rst_req;
  assign stat_n   = present && !flt_q;
endmodule

// File: rtl/csq_checker.sv
module csq_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_n,
  input logic pres_n,
  input logic pres,
  input logic ovc,
  input logic ovt,
  input logic alarm,
  input logic boost_en,
  input logic vcc_en,
  input logic io_en,
  input logic clk_en,
  input logic card_rst,
  input logic stat_n
);
  logic card_in;
  assign card_in = !pres_n || pres;

  a_r10_io_needs_vcc: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);
  a_r10_vcc_needs_boost: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_en |-> boost_en);
  a_r10_clk_needs_io: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en);
  a_r10_rst_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> clk_en);
  a_r7_stat_needs_card: assert property (@(posedge clk) disable iff (!rst_n)
    stat_n |-> card_in);
  a_r2_start_conditions: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boost_en) |-> (!$past(cmd_n) && !$past(alarm) && $past(card_in)));
  a_r8_overcurrent_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rst && !cmd_n && (ovc || ovt)) |=> (!card_rst && !stat_n));
  a_r9_alarm_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rst && !cmd_n && alarm && !ovc && !ovt && card_in)
      |=> (!card_rst && (stat_n == card_in)));
endmodule

bind csq_sequencer csq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_n    (cmd_n),
  .pres_n   (pres_n),
  .pres     (pres),
  .ovc      (ovc),
  .ovt      (ovt),
  .alarm    (alarm),
  .boost_en (boost_en),
  .vcc_en   (vcc_en),
  .io_en    (io_en),
  .clk_en   (clk_en),
  .card_rst (card_rst),
  .stat_n   (stat_n)
);

// File: tb/csq_sequencer_bench.sv
module csq_sequencer_bench;
  localparam int unsigned OSC = 8;
  localparam int unsigned HOLD = 40;

  logic clk, rst_n, cmd_n, rst_req, pres_n, pres, ovc, ovt, alarm;
  logic boost_en, vcc_en, io_en, clk_en, card_rst, stat_n;
  int   n_cmp, n_bad;

  csq_sequencer #(.OSC_PER_T(OSC), .HOLD_CYCLES(HOLD)) u_csq_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .rst_req(rst_req),
    .pres_n(pres_n), .pres(pres), .ovc(ovc), .ovt(ovt), .alarm(alarm),
    .boost_en(boost_en), .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en),
    .card_rst(card_rst), .stat_n(stat_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [4:0] outs();
    return {boost_en, vcc_en, io_en, clk_en, card_rst};
  endfunction

  // expected {boost,vcc,io,clk,rst} k falling edges after the command edge (H=4)
  function automatic logic [4:0] act_vec(int k, int cs, logic rq);
    return {1'b1, k >= 13, k >= 33, k >= cs, (k >= 57) && rq};
  endfunction

  function automatic logic [4:0] dea_vec(int k);
    return {k < 41, k < 13, k < 9, k < 5, 1'b0};
  endfunction

  function automatic int clk_start(logic gated, int r);
    if (!gated || r < 32) return 33;
    if (r >= 56) return 57;
    return r + 1;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // starts from idle with cmd_n high; leaves an active session, cmd_n low
  task automatic run_act(input logic gated, input int r);
    int cs;
    logic [4:0] e;
    cs = clk_start(gated, r);
    rst_req = gated;
    @(negedge clk);
    cmd_n = 1'b0;
    for (int k = 1; k <= 57; k++) begin
      @(negedge clk);
      e = act_vec(k, cs, gated && (r >= k));
      chk("R3", {5'd0, outs()} & 8'h1c, {5'd0, e} & 8'h1c);
      chk("R4", {7'd0, clk_en}, {7'd0, e[1]});
      chk("R5", {7'd0, card_rst}, {7'd0, e[0]});
      if (gated && k == r) rst_req = 1'b0;
    end
    rst_req = 1'b0;
  endtask

  // trigger already applied at the preceding falling edge
  task automatic run_dea(input string tag, input logic exp_stat, input bit revive);
    for (int k = 1; k <= 42; k++) begin
      @(negedge clk);
      chk(tag, {3'd0, outs()}, {3'd0, dea_vec(k)});
      chk("R7", {7'd0, stat_n}, {7'd0, exp_stat});
      if (revive && k == 3) begin pres = 1'b1; end
    end
  endtask

  initial begin
    int unsigned sd;
    n_cmp = 0; n_bad = 0;
    sd = $urandom(32'd5150);
    rst_n = 0; cmd_n = 1; rst_req = 0; pres_n = 1; pres = 0;
    ovc = 0; ovt = 0; alarm = 0;
    repeat (3) @(negedge clk);
    chk("R1", {3'd0, outs()}, 8'd0);
    chk("R7", {7'd0, stat_n}, 8'd0);
    rst_n = 1;
    @(negedge clk); pres_n = 0;
    @(negedge clk); chk("R7", {7'd0, stat_n}, 8'd1);
    pres_n = 1; pres = 1;
    @(negedge clk); chk("R7", {7'd0, stat_n}, 8'd1);
    cmd_n = 0;
    repeat (20) @(negedge clk);
    chk("R1", {7'd0, boost_en}, 8'd0);
    cmd_n = 1;
    repeat (40) @(negedge clk);

    // plain activation, reset follow, normal deactivation
    run_act(1'b0, 0);
    rst_req = 1; @(negedge clk); chk("R5", {7'd0, card_rst}, 8'd1);
    rst_req = 0; @(negedge clk); chk("R5", {7'd0, card_rst}, 8'd0);
    cmd_n = 1;
    run_dea("R6", 1'b1, 0);

    // random release points of the reset request
    for (int i = 0; i < 5; i++) begin
      int r;
      r = (i == 0) ? 31 : 20 + int'($urandom_range(40));
      run_act(1'b1, r);
      cmd_n = 1;
      run_dea("R6", 1'b1, 0);
    end

    // card removal with bounce back, latch holds status low
    run_act(1'b0, 0);
    pres = 0;
    run_dea("R8", 1'b0, 1);
    repeat (10) @(negedge clk);
    chk("R11", {7'd0, boost_en}, 8'd0);
    chk("R8", {7'd0, stat_n}, 8'd0);
    cmd_n = 1;
    @(negedge clk); chk("R8", {7'd0, stat_n}, 8'd1);
    repeat (3) @(negedge clk);

    // overcurrent early in activation: supply never comes up
    @(negedge clk); cmd_n = 0;
    repeat (5) @(negedge clk);
    ovc = 1; @(negedge clk); ovc = 0;
    for (int k = 2; k <= 42; k++) begin
      @(negedge clk);
      chk("R6", {3'd0, outs()}, {3'd0, k < 41, 4'd0});
      chk("R8", {7'd0, stat_n}, 8'd0);
    end
    cmd_n = 1; repeat (3) @(negedge clk);

    // overtemperature in session
    run_act(1'b0, 0);
    ovt = 1; rst_req = 1; @(negedge clk); ovt = 0;
    chk("R8", {6'd0, card_rst, stat_n}, 8'd0);
    repeat (41) @(negedge clk);
    cmd_n = 1; repeat (3) @(negedge clk);

    // supply alarm in session, then hold after release
    run_act(1'b0, 0);
    rst_req = 1; alarm = 1; @(negedge clk);
    chk("R9", {6'd0, card_rst, stat_n}, 8'd1);
    rst_req = 0;
    repeat (45) @(negedge clk);
    chk("R9", {3'd0, outs()}, 8'd0);
    chk("R9", {7'd0, stat_n}, 8'd1);
    alarm = 0; cmd_n = 1; @(negedge clk); cmd_n = 0;
    repeat (30) @(negedge clk);
    chk("R1", {7'd0, boost_en}, 8'd0);
    repeat (15) @(negedge clk);
    chk("R2", {7'd0, boost_en}, 8'd1);
    cmd_n = 1; repeat (60) @(negedge clk);
    chk("R6", {3'd0, outs()}, 8'd0);

    // no card: no start
    pres = 0; cmd_n = 0;
    repeat (10) @(negedge clk);
    chk("R2", {7'd0, boost_en}, 8'd0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule